// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block protects a whole NAND page with one single-error-correcting, double-error-detecting Hamming code. It computes the code as data words stream past on the flash data bus. A page of 512, 1024, 2048 or 4096 data bytes is treated as one code word, with no sub-blocks. On a write pass the engine accumulates a 16-bit parity and a 16-bit inverted parity, and the host stores these as four check bytes in the spare area. On a verify pass the stored check bytes are streamed in directly after the last data word. The engine XORs them against the recomputed code and classifies the result.

The result is a location word, which holds the bit offset in bits [3:0] and the word address in bits [15:4], plus three flags. One flag marks any detected error. One marks an error that cannot be corrected. One marks a single flipped bit inside the check bytes. A freshly erased page (all 0xFF, including the check bytes) shows as an uncorrectable result whose location reads 0xFFFF, so software can recognise it. The word width is 8 or 16 bits, chosen by parameter. The actual bit repair in memory is left to the host.

Top module: `nand_page_ecc`

## Requirements
- R1: `cfg_size_i` selects the data length: 0 gives 512 bytes, 1 gives 1024, 2 gives 2048 and 3 gives 4096. The word count is that length divided by the word width in bytes, and a word index never passes the last word of the selected page.
- R2: A `cfg_we_i` or `page_start_i` strobe clears the parity, inverted parity, location and all flags, starting a new page. Out of reset the same cleared state holds, with size code 0.
- R3: Each data bit has the position pos = {word index[11:0], bit index[3:0]}. `par_o[k]` is the XOR of pos[k] over all data bits equal to 1. `npar_o[k]` is the XOR of the inverted pos[k] over those bits, restricted to the position bits in use: bit indices below the word width, and word-index bits below log2(word count).
- R4: `done_o` is high for exactly one cycle. It is raised in the cycle after the last data word on a write pass, or in the cycle after the fourth check byte on a verify pass.
- R5: On a verify pass (`page_verify_i`=1 at `page_start_i`), four check beats follow the data in `beat_data_i[7:0]`, in this order: par[7:0], par[15:8], npar[7:0], npar[15:8].
- R6: When the stored check bytes equal the recomputed code, all three flags stay low and `loc_o` reads 0.
- R7: A single flipped data bit sets only `err_det_o`, and `loc_o` gives that bit's position.
- R8: A single flipped bit among the 32 stored check bits sets `err_det_o` and `err_chk_o`, and leaves `err_multi_o` low.
- R9: Any other nonzero difference sets `err_det_o` and `err_multi_o`, with `loc_o` equal to the recomputed parity XOR the stored parity. An erased page (all 0xFF data and check bytes) therefore reports multi with `loc_o` = 0xFFFF.
- R10: Beats arriving after `done_o` and before the next clear strobe are ignored. The parity, flags and location stay unchanged and no further done is raised.
- R11: Cycles with `beat_valid_i` low are ignored, so idle gaps inside a page do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Page-size mode write strobe, also clears the page state |
| cfg_size_i | input | 2 | Page-size code |
| page_start_i | input | 1 | New-page strobe, clears the page state |
| page_verify_i | input | 1 | Sampled with page_start_i: 1 makes the pass a verify pass |
| beat_valid_i | input | 1 | A data or check beat is present |
| beat_data_i | input | WORD_W | Data word, or a check byte in bits [7:0] |
| done_o | output | 1 | One-cycle page-complete pulse |
| par_o | output | 16 | Accumulated parity of the page |
| npar_o | output | 16 | Accumulated masked inverted parity |
| loc_o | output | 16 | Error location / parity syndrome after a verify pass |
| err_det_o | output | 1 | Nonzero syndrome seen |
| err_multi_o | output | 1 | Uncorrectable pattern |
| err_chk_o | output | 1 | Single bit error inside the check bytes |

## Verification
The fourth check byte is taken in and the full syndrome is classified in the same cycle. This is where the last stored byte and the compare collide. The bench provokes the collision by corrupting a bit in that final byte (inverted parity high byte), so a result formed from a stale byte would show as clean. The bench judges it at the done pulse by expecting the check-bit flag with a zero location. The error at the very last data word of 2048- and 4096-word pages stresses the collision of the counter's final word with the switch to the check phase.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        PH_DATA  = 2'd0,
        PH_CHECK = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e      ph;
        logic [11:0] cnt;
        logic [1:0]  size;
        logic        verify;
        logic [1:0]  beat;
        logic [23:0] held;
        logic [15:0] par;
        logic [15:0] npar;
        logic [15:0] loc;
        logic        det;
        logic        multi;
        logic        chk;
        logic        done;
    } ecc_state_t;

    // number of data words in a page for a size code and word width
    function automatic logic [12:0] data_words(input logic [1:0] size, input int word_w);
        logic [12:0] bytes;
        bytes = 13'd512 << size;
        return (word_w == 16) ? (bytes >> 1) : bytes;
    endfunction

    // position bits that exist for a size code and word width
    function automatic logic [15:0] pos_mask(input logic [1:0] size, input int word_w);
        int          abits;
        logic [15:0] wm;
        abits = 9 + int'(size) - ((word_w == 16) ? 1 : 0);
        wm    = ((16'd1 << abits) - 16'd1) << 4;
        return wm | ((word_w == 16) ? 16'h000F : 16'h0007);
    endfunction

endpackage

// File: rtl/nand_ecc_word_par.sv
module nand_ecc_word_par #(
    parameter int WORD_W = 8
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [11:0]       widx_i,
    output logic [15:0]       p_o,
    output logic [15:0]       np_o
);
    logic xall;
    assign xall = ^word_i;

    // offset bits: fold the word bits whose index has bit k set / clear
    for (genvar k = 0; k < 4; k++) begin : g_off
        always_comb begin
            p_o[k]  = 1'b0;
            np_o[k] = 1'b0;
            for (int b = 0; b < WORD_W; b++) begin
                if (b[k]) p_o[k]  = p_o[k] ^ word_i[b];
                else      np_o[k] = np_o[k] ^ word_i[b];
            end
        end
    end

    // word-address bits: whole-word parity steered by the index bit
    for (genvar k = 4; k < 16; k++) begin : g_addr
        assign p_o[k]  = widx_i[k-4] & xall;
        assign np_o[k] = ~widx_i[k-4] & xall;
    end

endmodule

// File: rtl/nand_ecc_classify.sv
module nand_ecc_classify (
    input  logic [15:0] comp_par_i,
    input  logic [15:0] comp_npar_i,
    input  logic [31:0] stored_i,
    input  logic [15:0] mask_i,
    output logic [15:0] loc_o,
    output logic        det_o,
    output logic        multi_o,
    output logic        chk_o
);
    logic [15:0] syn_p;
    logic [15:0] syn_np;
    logic        is_zero;
    logic        is_fix;
    logic        is_one;

    always_comb begin
        syn_p   = comp_par_i ^ stored_i[15:0];
        syn_np  = comp_npar_i ^ stored_i[31:16];
        is_zero = (syn_p == 16'd0) && (syn_np == 16'd0);
        is_fix  = (syn_np == (~syn_p & mask_i)) && ((syn_p & ~mask_i) == 16'd0);
        is_one  = $onehot({syn_np, syn_p});
        loc_o   = syn_p;
        det_o   = !is_zero;
        chk_o   = is_one;
        multi_o = !is_zero && !is_fix && !is_one;
    end

endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
    import nand_ecc_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_size_i,
    input  logic              page_start_i,
    input  logic              page_verify_i,
    input  logic              beat_valid_i,
    input  logic [WORD_W-1:0] beat_data_i,
    output logic              done_o,
    output logic [15:0]       par_o,
    output logic [15:0]       npar_o,
    output logic [15:0]       loc_o,
    output logic              err_det_o,
    output logic              err_multi_o,
    output logic              err_chk_o
);
    localparam int CHK_LAST = 3;

    ecc_state_t q, d;

    logic [15:0] mask;
    logic [11:0] last_idx;
    logic [15:0] wp, wnp;
    logic [15:0] c_loc;
    logic        c_det, c_multi, c_chk;

    assign mask     = pos_mask(q.size, WORD_W);
    assign last_idx = 12'(data_words(q.size, WORD_W) - 13'd1);

    nand_ecc_word_par #(.WORD_W(WORD_W)) u_wpar (
        .word_i (beat_data_i),
        .widx_i (q.cnt),
        .p_o    (wp),
        .np_o   (wnp)
    );

    nand_ecc_classify u_cls (
        .comp_par_i  (q.par),
        .comp_npar_i (q.npar),
        .stored_i    ({beat_data_i[7:0], q.held}),
        .mask_i      (mask),
        .loc_o       (c_loc),
        .det_o       (c_det),
        .multi_o     (c_multi),
        .chk_o       (c_chk)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (cfg_we_i || page_start_i) begin
            d.ph    = PH_DATA;
            d.cnt   = '0;
            d.beat  = '0;
            d.held  = '0;
            d.par   = '0;
            d.npar  = '0;
            d.loc   = '0;
            d.det   = 1'b0;
            d.multi = 1'b0;
            d.chk   = 1'b0;
            if (cfg_we_i) begin
                d.size   = cfg_size_i;
                d.verify = 1'b0;
            end
            if (page_start_i) d.verify = page_verify_i;
        end else if (beat_valid_i) begin
            case (q.ph)
                PH_DATA: begin
                    d.par  = q.par ^ wp;
                    d.npar = q.npar ^ (wnp & mask);
                    if (q.cnt == last_idx) begin
                        if (q.verify) d.ph = PH_CHECK;
                        else begin
                            d.ph   = PH_DONE;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 12'd1;
                    end
                end
                PH_CHECK: begin
                    case (q.beat)
                        2'd0:    d.held[7:0]   = beat_data_i[7:0];
                        2'd1:    d.held[15:8]  = beat_data_i[7:0];
                        2'd2:    d.held[23:16] = beat_data_i[7:0];
                        default: d.held        = q.held;
                    endcase
                    d.beat = q.beat + 2'd1;
                    if (q.beat == 2'(CHK_LAST)) begin
                        d.ph    = PH_DONE;
                        d.done  = 1'b1;
                        d.loc   = c_loc;
                        d.det   = c_det;
                        d.multi = c_multi;
                        d.chk   = c_chk;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.ph    <= PH_DATA;
        end else begin
            q <= d;
        end
    end

    assign done_o      = q.done;
    assign par_o       = q.par;
    assign npar_o      = q.npar;
    assign loc_o       = q.loc;
    assign err_det_o   = q.det;
    assign err_multi_o = q.multi;
    assign err_chk_o   = q.chk;

    assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cnt <= last_idx);

    assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i || page_start_i) |=> (!err_det_o && par_o == 16'd0 && loc_o == 16'd0));

    assert_chk_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_chk_o |-> (err_det_o && !err_multi_o));

    assert_multi_det_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_multi_o |-> err_det_o);

    assert_ignore_after_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.ph == PH_DONE && !cfg_we_i && !page_start_i) |=> ($stable(par_o) && $stable(err_det_o) && !done_o));

endmodule

// File: tb/sim_nand_page_ecc.sv
module sim_nand_page_ecc;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, page_start, page_verify, beat_valid;
    logic [1:0]  cfg_size;
    logic [7:0]  beat_data;
    logic        done_o, err_det, err_multi, err_chk;
    logic [15:0] par_o, npar_o, loc_o;

    always #5 clk = ~clk;

    nand_page_ecc #(.WORD_W(8)) u0 (
        .clk_i (clk), .rst_ni (rst_n),
        .cfg_we_i (cfg_we), .cfg_size_i (cfg_size),
        .page_start_i (page_start), .page_verify_i (page_verify),
        .beat_valid_i (beat_valid), .beat_data_i (beat_data),
        .done_o (done_o), .par_o (par_o), .npar_o (npar_o), .loc_o (loc_o),
        .err_det_o (err_det), .err_multi_o (err_multi), .err_chk_o (err_chk)
    );

    typedef struct {
        logic [15:0] par, npar, loc;
        logic        det, multi, chk;
        string       req;
    } exp_t;

    exp_t        sbq[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [7:0]  pg [4096];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mask_of(input int size);
        return 16'((((1 << (9 + size)) - 1) << 4) | 7);
    endfunction

    // code from the position definition: XOR of the positions of all set bits
    function automatic logic [31:0] model(input int size);
        logic [15:0] p = 16'd0, np = 16'd0, m, pos;
        m = mask_of(size);
        for (int w = 0; w < (512 << size); w++)
            for (int b = 0; b < 8; b++)
                if (pg[w][b]) begin
                    pos = 16'((w << 4) | b);
                    p  ^= pos;
                    np ^= ~pos & m;
                end
        return {np, p};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(par_o == e.par,     e.req, "par",   32'(par_o),  32'(e.par));
                check(npar_o == e.npar,   e.req, "npar",  32'(npar_o), 32'(e.npar));
                check(loc_o == e.loc,     e.req, "loc",   32'(loc_o),  32'(e.loc));
                check(err_det == e.det,   e.req, "det",   32'(err_det), 32'(e.det));
                check(err_multi == e.multi, e.req, "multi", 32'(err_multi), 32'(e.multi));
                check(err_chk == e.chk,   e.req, "chk",   32'(err_chk), 32'(e.chk));
            end
        end
    end

    task automatic set_size(input int s);
        @(negedge clk); cfg_we = 1'b1; cfg_size = 2'(s);
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic run_page(input int size, input bit verify, input logic [31:0] stored,
                            input bit gaps, input exp_t e);
        sbq.push_back(e);
        @(negedge clk); page_start = 1'b1; page_verify = verify;
        @(negedge clk); page_start = 1'b0;
        for (int w = 0; w < (512 << size); w++) begin
            if (gaps && (w % 7 == 3)) begin
                @(negedge clk); beat_valid = 1'b0;
            end
            @(negedge clk); beat_valid = 1'b1; beat_data = pg[w];
        end
        if (verify)
            for (int i = 0; i < 4; i++) begin
                @(negedge clk); beat_valid = 1'b1; beat_data = stored[8*i +: 8];
            end
        @(negedge clk); beat_valid = 1'b0;
        check(done_o == 1'b1, "R4", "done after last beat", 32'(done_o), 32'd1);
        @(negedge clk);
        check(done_o == 1'b0, "R4", "done single cycle", 32'(done_o), 32'd0);
    endtask

    function automatic exp_t mk(input logic [31:0] c, input logic [15:0] loc,
                                input bit det, input bit mul, input bit chk, input string req);
        exp_t e;
        e.par = c[15:0]; e.npar = c[31:16]; e.loc = loc;
        e.det = det; e.multi = mul; e.chk = chk; e.req = req;
        return e;
    endfunction

    bit finished = 0;

    initial begin
        logic [31:0] good, fed;
        logic [15:0] hold;
        rst_n = 1'b0; cfg_we = 0; cfg_size = 0; page_start = 0; page_verify = 0;
        beat_valid = 0; beat_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o == 0 && err_det == 0 && err_multi == 0 && err_chk == 0, "R2",
              "reset flags", {err_det, err_multi, err_chk, done_o}, 32'd0);
        check(par_o == 0 && npar_o == 0 && loc_o == 0, "R2", "reset regs",
              {par_o, npar_o}, 32'd0);

        // R3: write pass, 512-byte page
        for (int w = 0; w < 4096; w++) pg[w] = 8'($urandom);
        good = model(0);
        run_page(0, 0, 32'd0, 0, mk(good, 16'd0, 0, 0, 0, "R3"));

        // R5 R6: clean verify
        run_page(0, 1, good, 0, mk(good, 16'd0, 0, 0, 0, "R6"));

        // R7 R11: single data bit with gaps
        pg[100][5] = ~pg[100][5];
        fed = model(0);
        run_page(0, 1, good, 1, mk(fed, 16'((100 << 4) | 5), 1, 0, 0, "R7"));
        pg[100][5] = ~pg[100][5];

        // R8: flipped bit in the final check byte (npar bit 12)
        run_page(0, 1, good ^ 32'h1000_0000, 0, mk(good, 16'd0, 1, 0, 1, "R8"));
        // R8: flipped parity bit 3
        run_page(0, 1, good ^ 32'h0000_0008, 0, mk(good, 16'h0008, 1, 0, 1, "R8"));

        // R9: two data bits
        pg[7][0] = ~pg[7][0]; pg[300][6] = ~pg[300][6];
        fed = model(0);
        run_page(0, 1, good, 0, mk(fed, 16'(((7 << 4) | 0) ^ ((300 << 4) | 6)), 1, 1, 0, "R9"));

        // R9: erased page
        for (int w = 0; w < 4096; w++) pg[w] = 8'hFF;
        fed = model(0);
        run_page(0, 1, 32'hFFFF_FFFF, 0, mk(fed, 16'hFFFF, 1, 1, 0, "R9"));

        // R2: mode write clears flags left by the erased page
        set_size(2);
        check(err_det == 0 && err_multi == 0 && loc_o == 0 && par_o == 0, "R2",
              "cfg clear", {err_det, err_multi, loc_o}, 32'd0);

        // R1: 2048-byte page, error in the last word
        for (int w = 0; w < 4096; w++) pg[w] = 8'($urandom);
        good = model(2);
        run_page(2, 0, 32'd0, 0, mk(good, 16'd0, 0, 0, 0, "R1"));
        pg[2047][7] = ~pg[2047][7];
        fed = model(2);
        run_page(2, 1, good, 0, mk(fed, 16'h7FF7, 1, 0, 0, "R1"));

        // R1: 1024-byte page write pass
        set_size(1);
        good = model(1);
        run_page(1, 0, 32'd0, 1, mk(good, 16'd0, 0, 0, 0, "R1"));

        // R1 R7: 4096-byte page, error at last word bit 0
        set_size(3);
        good = model(3);
        pg[4095][0] = ~pg[4095][0];
        fed = model(3);
        run_page(3, 1, good, 0, mk(fed, 16'hFFF0, 1, 0, 0, "R7"));

        // R10: extra beats after done are ignored
        hold = par_o;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); beat_valid = 1'b1; beat_data = 8'h5A + 8'(i);
        end
        @(negedge clk); beat_valid = 1'b0;
        @(negedge clk);
        check(par_o == hold, "R10", "par after extra beats", 32'(par_o), 32'(hold));
        check(err_det == 1'b1 && loc_o == 16'hFFF0, "R10", "status after extra beats",
              {err_det, loc_o}, {1'b1, 16'hFFF0});

        // R2: page start clears
        @(negedge clk); page_start = 1'b1; page_verify = 1'b0;
        @(negedge clk); page_start = 1'b0;
        check(err_det == 0 && loc_o == 0 && par_o == 0 && npar_o == 0, "R2",
              "start clear", {err_det, loc_o}, 32'd0);

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R4", "all pages completed", 32'(sbq.size()), 32'd0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule